// File: doc/BRIEF.md
# Registered Pass-Through Static Memory

This block is a single-clock static memory with a separate write-data input and read-data output. Every input is captured in a register on the rising clock edge: address, write data and the three active-low controls (write strobe, chip enable and output drive). The output word and its drive flag are also registered. Read data and passed-through write data therefore both reach the output one edge after the edge that captured the request.

The control scheme is unusual. Chip enable never deselects the memory. It only decides whether a write cycle updates the array. On every write cycle the captured write data is forwarded to the output register, whether or not the array is written. Whether the output drives depends only on the registered output-drive control. A tri-stated bus is modelled as a data bus plus a drive flag.

The full organisation is 2^17 words of 9 bits. The address width defaults to 10 so that simulation stays small, and it can be set to 17 for the full depth. Array contents are undefined until a word is written.

Top module: `srpt_top`

## Requirements
- R1: When a cycle is sampled with `wr_n_i` low, the output word after the following rising edge equals the write data sampled on that cycle, whatever the level of `ce_n_i`.
- R2: A cycle sampled with both `wr_n_i` and `ce_n_i` low stores the write data at the sampled address, and a later read of that address returns it.
- R3: A cycle sampled with `wr_n_i` low and `ce_n_i` high leaves the array unchanged. A later read of that address returns the word stored before it.
- R4: A cycle sampled with `wr_n_i` high loads the word at the sampled address into the output register. The word appears after the following rising edge, the same latency as in R1.
- R5: `drive_o` after an edge equals the inverse of `oe_n_i` as sampled one edge earlier. `ce_n_i` and `wr_n_i` never change `drive_o`, so a read with `ce_n_i` high still drives.
- R6: A read of an address on the cycle right after a write to that address returns the newly written data.
- R7: While `rst_n` is low, and on the first edge after its release, `drive_o` is 0 and `rdat_o` is 0. The registered controls reset to the inactive (no write, no drive) state.
- R8: A write sampled while `oe_n_i` is high still updates the array, even though the output is not driven.
- R9: Writes on consecutive cycles to different addresses, including address 0 and the highest address, each store their own word.
- R10: The address width `AW` and data width `DW` are parameters. The depth is 2^AW words, and the full organisation is AW=17, DW=9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers (not the array) |
| addr_i | input | AW | Word address |
| wdat_i | input | DW | Write data |
| wr_n_i | input | 1 | Active-low write strobe |
| ce_n_i | input | 1 | Active-low chip enable; gates only the array write |
| oe_n_i | input | 1 | Active-low output drive control |
| rdat_o | output | DW | Registered output word |
| drive_o | output | 1 | 1 when the output is driven, 0 for high impedance |

## Verification
A wrong captured control shows at the ports one edge after the capture. The drive flag or the forwarded word is wrong on the very next output sample. A wrong array write stays hidden until that address is read again, so every write is followed by reads of the same address. Those reads come immediately after the write and after intervening cycles with chip enable high. The bench reads back at least one later, which bounds the detection delay at the length of the sequence. Writes with chip enable high are always to addresses that already hold a known word, so a wrongly blocked or wrongly allowed write shows as a mismatch.

// File: rtl/srpt_pkg.sv
package srpt_pkg;

    // Decoded controls, active high, as held in the input register.
    typedef struct packed {
        logic wr;   // write cycle (pass-through, maybe array write)
        logic ce;   // array write permitted
        logic oe;   // output drive requested
    } srpt_ctl_t;

    localparam srpt_ctl_t SRPT_CTL_IDLE = '{wr: 1'b0, ce: 1'b0, oe: 1'b0};

    function automatic srpt_ctl_t srpt_decode(input logic wr_n, input logic ce_n,
                                              input logic oe_n);
        srpt_ctl_t c;
        c.wr = ~wr_n;
        c.ce = ~ce_n;
        c.oe = ~oe_n;
        return c;
    endfunction

endpackage

// File: rtl/srpt_in_reg.sv
module srpt_in_reg
    import srpt_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdat_i,
    input  logic          wr_n_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    output logic [AW-1:0] addr_q_o,
    output logic [DW-1:0] wdat_q_o,
    output srpt_ctl_t     ctl_q_o,
    output logic          arr_we_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        srpt_ctl_t     ctl;
    } in_st_t;

    in_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.addr = addr_i;
        st_d.wdat = wdat_i;
        st_d.ctl  = srpt_decode(wr_n_i, ce_n_i, oe_n_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= '0;
            st_q.wdat <= '0;
            st_q.ctl  <= SRPT_CTL_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q_o = st_q.addr;
    assign wdat_q_o = st_q.wdat;
    assign ctl_q_o  = st_q.ctl;
    // Array write needs both the write strobe and chip enable.
    assign arr_we_o = st_q.ctl.wr & st_q.ctl.ce;

endmodule

// File: rtl/srpt_array.sv
module srpt_array #(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdat_i,
    output logic [DW-1:0] rdat_o
);

    localparam int DEPTH = 1 << AW;

    // Storage carries no reset: contents are undefined until written.
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdat_i;
        end
    end

    // Asynchronous read; the output stage registers it.
    assign rdat_o = mem_q[addr_i];

endmodule

// File: rtl/srpt_out_stage.sv
module srpt_out_stage
    import srpt_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  srpt_ctl_t     ctl_q_i,
    input  logic [DW-1:0] wdat_q_i,
    input  logic [DW-1:0] rdat_i,
    output logic [DW-1:0] rdat_o,
    output logic          drive_o
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          drive;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // A write cycle always forwards its data, whether or not the array was written.
        st_d.data  = ctl_q_i.wr ? wdat_q_i : rdat_i;
        st_d.drive = ctl_q_i.oe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdat_o  = st_q.data;
    assign drive_o = st_q.drive;

endmodule

// File: rtl/srpt_top.sv
module srpt_top
    import srpt_pkg::*;
#(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdat_i,
    input  logic          wr_n_i,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    output logic [DW-1:0] rdat_o,
    output logic          drive_o
);

    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdat_q;
    srpt_ctl_t     ctl_q;
    logic          arr_we;
    logic [DW-1:0] arr_rdat;

    srpt_in_reg #(.AW(AW), .DW(DW)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (addr_i),
        .wdat_i   (wdat_i),
        .wr_n_i   (wr_n_i),
        .ce_n_i   (ce_n_i),
        .oe_n_i   (oe_n_i),
        .addr_q_o (addr_q),
        .wdat_q_o (wdat_q),
        .ctl_q_o  (ctl_q),
        .arr_we_o (arr_we)
    );

    srpt_array #(.AW(AW), .DW(DW)) u_arr (
        .clk    (clk),
        .we_i   (arr_we),
        .addr_i (addr_q),
        .wdat_i (wdat_q),
        .rdat_o (arr_rdat)
    );

    srpt_out_stage #(.DW(DW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_q_i  (ctl_q),
        .wdat_q_i (wdat_q),
        .rdat_i   (arr_rdat),
        .rdat_o   (rdat_o),
        .drive_o  (drive_o)
    );

endmodule

// File: rtl/srpt_chk.sv
module srpt_chk #(
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] wdat_i,
    input logic          wr_n_i,
    input logic          ce_n_i,
    input logic          oe_n_i,
    input logic [DW-1:0] rdat_o,
    input logic          drive_o,
    input logic          arr_we
);

    // Edges seen since reset release, saturating; guards the two-deep $past.
    logic [1:0] age_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    AST_DRIVE_FOLLOWS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (drive_o == !$past(oe_n_i, 2)));  // R5

    AST_NO_DRIVE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && $past(oe_n_i, 2)) |-> !drive_o);  // R5

    AST_WRITE_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && !$past(wr_n_i, 2)) |-> (rdat_o == $past(wdat_i, 2)));  // R1

    AST_CE_BLOCKS_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1 && $past(ce_n_i)) |-> !arr_we);  // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!drive_o && rdat_o == '0));  // R7

endmodule

bind srpt_top srpt_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdat_i  (wdat_i),
    .wr_n_i  (wr_n_i),
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .rdat_o  (rdat_o),
    .drive_o (drive_o),
    .arr_we  (arr_we)
);

// File: tb/sim_srpt_top.sv
`timescale 1ns/1ps
module sim_srpt_top;

    localparam int AW = 10;
    localparam int DW = 9;
    localparam int DEPTH = 1 << AW;
    localparam int MAXCYC = 200000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] wdat_i = '0;
    logic          wr_n_i = 1'b1;
    logic          ce_n_i = 1'b1;
    logic          oe_n_i = 1'b1;
    logic [DW-1:0] rdat_o;
    logic          drive_o;

    always #2 clk = ~clk;

    srpt_top #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdat_i(wdat_i),
        .wr_n_i(wr_n_i), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i),
        .rdat_o(rdat_o), .drive_o(drive_o)
    );

    typedef struct {
        logic          drv;
        logic          known;
        logic [DW-1:0] data;
        string         req;
    } exp_t;

    exp_t          sb[$];
    exp_t          staged;
    bit            staged_v = 0;
    bit            run = 0;
    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_known [DEPTH];
    int            errs = 0;
    int            checks = 0;
    int            cyc = 0;
    bit            done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Driver: applies one cycle of inputs and pushes the expected output.
    task automatic drive(input logic [AW-1:0] a, input logic [DW-1:0] dv,
                         input logic wn, input logic cn, input logic on,
                         input string req);
        exp_t e;
        @(negedge clk);
        addr_i = a; wdat_i = dv; wr_n_i = wn; ce_n_i = cn; oe_n_i = on;
        e.drv = !on;
        e.req = req;
        if (!wn) begin
            e.known = 1'b1;
            e.data  = dv;
            if (!cn) begin
                ref_mem[a]   = dv;
                ref_known[a] = 1'b1;
            end
        end else begin
            e.known = ref_known[a];
            e.data  = ref_known[a] ? ref_mem[a] : '0;
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive('0, '0, 1'b1, 1'b1, 1'b1, "R5");
    endtask

    // Monitor: item pushed before edge n is compared just after edge n+1.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (run) begin
            if (staged_v) begin
                check(drive_o == staged.drv, staged.req, "drive", int'(drive_o),
                      int'(staged.drv));
                if (staged.drv && staged.known)
                    check(rdat_o == staged.data, staged.req, "data", int'(rdat_o),
                          int'(staged.data));
                staged_v = 0;
            end
            if (sb.size() > 0) begin
                staged   = sb.pop_front();
                staged_v = 1;
            end
        end
    end

    initial begin
        wait (cyc >= MAXCYC);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, MAXCYC);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_known[i] = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state
        check(drive_o == 1'b0, "R7", "drive in reset", int'(drive_o), 0);
        check(rdat_o == '0, "R7", "data in reset", int'(rdat_o), 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(drive_o == 1'b0, "R7", "drive after release", int'(drive_o), 0);
        run = 1;

        // R1, R2: transparent writes
        drive(10'd5,   9'h1A5, 1'b0, 1'b0, 1'b0, "R1");
        drive(10'd6,   9'h05A, 1'b0, 1'b0, 1'b0, "R1");
        drive(10'd7,   9'h1FF, 1'b0, 1'b0, 1'b0, "R2");
        idle(1);
        // R4: reads back
        drive(10'd5,   9'h000, 1'b1, 1'b0, 1'b0, "R4");
        drive(10'd7,   9'h000, 1'b1, 1'b0, 1'b0, "R4");
        drive(10'd6,   9'h000, 1'b1, 1'b0, 1'b0, "R2");
        // R3: chip enable high blocks the array but still forwards
        drive(10'd5,   9'h0F3, 1'b0, 1'b1, 1'b0, "R3");
        drive(10'd5,   9'h000, 1'b1, 1'b0, 1'b0, "R3");
        drive(10'd6,   9'h111, 1'b0, 1'b1, 1'b0, "R3");
        idle(2);
        drive(10'd6,   9'h000, 1'b1, 1'b1, 1'b0, "R3");
        // R6: read right after write
        drive(10'd9,   9'h13C, 1'b0, 1'b0, 1'b0, "R6");
        drive(10'd9,   9'h000, 1'b1, 1'b0, 1'b0, "R6");
        drive(10'd9,   9'h0C3, 1'b0, 1'b0, 1'b1, "R6");
        drive(10'd9,   9'h000, 1'b1, 1'b1, 1'b0, "R6");
        // R5: controls other than output drive do not change drive
        drive(10'd7,   9'h000, 1'b1, 1'b1, 1'b0, "R5");
        drive(10'd7,   9'h000, 1'b1, 1'b0, 1'b1, "R5");
        drive(10'd7,   9'h0AA, 1'b0, 1'b1, 1'b1, "R5");
        drive(10'd7,   9'h000, 1'b1, 1'b1, 1'b0, "R5");
        // R8: write with output off still stores
        drive(10'd20,  9'h099, 1'b0, 1'b0, 1'b1, "R8");
        idle(1);
        drive(10'd20,  9'h000, 1'b1, 1'b0, 1'b0, "R8");
        // R9, R10: burst of writes incl. extremes, then read back
        drive(10'd0,          9'h101, 1'b0, 1'b0, 1'b0, "R9");
        drive(10'(DEPTH - 1), 9'h1EE, 1'b0, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 16; i++)
            drive(10'(100 + i), 9'(i * 29 + 3), 1'b0, 1'b0, 1'b0, "R9");
        for (int i = 15; i >= 0; i--)
            drive(10'(100 + i), 9'h000, 1'b1, (i % 2 == 0), 1'b0, "R9");
        drive(10'd0,          9'h000, 1'b1, 1'b0, 1'b0, "R9");
        drive(10'(DEPTH - 1), 9'h000, 1'b1, 1'b0, 1'b0, "R10");
        idle(3);
        repeat (3) @(posedge clk);
        #2;
        run = 0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule